// File: doc/BRIEF.md
# Trace Packet Serializer Port

This block takes captured memory-write events from an upstream queue and sends each one off chip as a fixed 32-bit packet. The packet is cut into beats on a parallel data port whose width can be set to 2, 4, 8 or 16 pins. Each event carries a two-bit status, a two-bit target selector, a two-bit access size, an 18-bit address and one data byte. The port has its own clock, divided down from the system clock. That clock either runs all the time or is switched off whenever no packet is being sent.

The receiver sees a strobe on the first beat of every packet. It can hold off further traffic with a stall input. The block looks at the stall only when it is about to start a new packet, so a packet that has already started always goes out complete. All configuration inputs are static: they are set while the block is in reset and are not changed while it runs.

Top module: `trace_pkt_port`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `port_clk`, `port_sync` and `port_data` are all low.
- R2: With `cfg_div` = N, one period of the port clock is 2×(N+1) system clocks. In free-running mode (`cfg_freerun`=1) a rising edge of `port_clk` comes at that interval at all times.
- R3: In gated mode (`cfg_freerun`=0), when no packet is being sent, `port_clk` stays low and `port_sync` and `port_data` are zero.
- R4: Each packet is the 32-bit word {status[1:0], target[1:0], size[1:0], address[17:0], data[7:0]}, with status in the top bits. It is sent one beat per port-clock rising edge, most significant beat first.
- R5: `cfg_width` sets the number of active pins: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. A packet takes 32/pins beats, carried on `port_data` bits [pins-1:0]. The pins above the active ones stay low.
- R6: `port_sync` is high on the first beat of every packet and low on all other beats. `port_sync` and `port_data` change only together with a rising edge of the port clock. When the port is idle, these edges carry zero data and no sync.
- R7: The beats of one packet follow each other on consecutive port-clock periods, with no gap.
- R8: If the stall input rises while a packet is being sent, that packet still goes out with all of its beats.
- R9: While `stall_in` is high, no new packet starts. Once it falls, pending events are sent.
- R10: Every event is taken out of the queue by exactly one `evt_pop` pulse, and only when `evt_valid` is high. Events are sent in queue order, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Queue holds at least one event |
| evt_pop | output | 1 | Take the head event from the queue |
| evt_stat | input | 2 | Head event status field |
| evt_dest | input | 2 | Head event target selector |
| evt_size | input | 2 | Head event access size |
| evt_addr | input | 18 | Head event address |
| evt_data | input | 8 | Head event data byte |
| cfg_width | input | 2 | Port width code |
| cfg_div | input | 8 | Prescaler value N |
| cfg_freerun | input | 1 | 1: port clock runs all the time; 0: port clock is gated |
| stall_in | input | 1 | Receiver hold-off, acted on only between packets |
| port_clk | output | 1 | Generated port clock |
| port_sync | output | 1 | Packet start strobe |
| port_data | output | 16 | Beat data, active pins in the low bits |

## Verification
Two things can fall on the same port-clock edge: the last beat of a packet ending and the stall input stopping the next packet from starting. A queued event being taken on the same edge that ends the previous packet is the second case. The bench holds stall high and low for random lengths of time, so stall rises and falls both in the middle of packets and right at packet edges. Events are added while earlier ones are still being sent. The receiver model flags three faults: a strobe that shows up while a packet is still being collected (a cut-short packet), a packet that starts after stall has been high for two or more system cycles, and a gap between beats of one packet.

// File: rtl/trc_pkg.sv
// Shared field widths, width code and helper functions for the trace packet port.
// Assumes the packet fields add up to a word that every port width divides evenly.
package trc_pkg;
    localparam int STAT_W = 2;
    localparam int DEST_W = 2;
    localparam int SIZE_W = 2;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int WORD_W = STAT_W + DEST_W + SIZE_W + ADDR_W + DATA_W;
    localparam int PORT_W = 16;
    localparam int CNT_W  = $clog2(WORD_W / 2 + 1);

    typedef enum logic [1:0] {
        PW_2  = 2'b00,
        PW_4  = 2'b01,
        PW_8  = 2'b10,
        PW_16 = 2'b11
    } pw_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [DEST_W-1:0] dest;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } trc_evt_t;

    // Number of active pins for a width code.
    function automatic int pins_of(input pw_e w);
        return 2 << w;
    endfunction

    // Number of beats one packet takes at a width code.
    function automatic int beats_of(input pw_e w);
        return WORD_W / pins_of(w);
    endfunction
endpackage

// File: rtl/trc_clkdiv.sv
// Port clock prescaler. It toggles a phase bit every div+1 system cycles, so the
// port clock period is 2*(div+1) system cycles. rise_tick marks the system cycle
// whose closing edge drives the phase high. Assumes div is static while running.
module trc_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             rise_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Wrap when the half-period count is used up.
    assign wrap      = (cnt >= div);
    assign rise_tick = wrap & ~phase;

    // Half-period counter and phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= div)); // R2
    AST_PHASE_HOLDS_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap) |=> (phase == $past(phase))); // R2
endmodule

// File: rtl/trc_shift.sv
// Beat shifter. It loads a packet word on a port-clock tick and presents the top
// active pins of the word as the current beat. On each following tick it shifts by
// the port width until the beat count is used up. Assumes load comes only on a tick.
module trc_shift
    import trc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  pw_e               width,
    output logic [PORT_W-1:0] beat,
    output logic              active,
    output logic              last
);
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  left;
    int                pins;

    assign pins = pins_of(width);
    // No beats beyond the current one: a new packet may start on the next tick.
    assign last = (left <= CNT_W'(1));

    // Present the top active pins; pins above them read as zero.
    always_comb begin
        logic [WORD_W-1:0] top;
        top  = sh >> (WORD_W - pins);
        beat = active ? top[PORT_W-1:0] : '0;
    end

    // Load, shift by port width, or go idle on each port-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            left   <= '0;
            active <= 1'b0;
        end else if (tick) begin
            if (load) begin
                sh     <= word;
                left   <= CNT_W'(beats_of(width));
                active <= 1'b1;
            end else if (active && left > CNT_W'(1)) begin
                sh     <= sh << pins;
                left   <= left - 1'b1;
            end else begin
                active <= 1'b0;
                left   <= '0;
            end
        end
    end

    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (left <= CNT_W'(1))); // R8
    AST_ACTIVE_HAS_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (left != '0)); // R7
    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> tick); // R6
endmodule

// File: rtl/trace_pkt_port.sv
// Trace packet serializer port. It takes one queued write event per packet, drives
// a start strobe with the first beat and sends the word on the selected pins,
// paced by the divided port clock. Stall is looked at only when a packet may start.
// Assumes the configuration inputs are static outside reset.
module trace_pkt_port
    import trc_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    output logic              evt_pop,
    input  logic [STAT_W-1:0] evt_stat,
    input  logic [DEST_W-1:0] evt_dest,
    input  logic [SIZE_W-1:0] evt_size,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    input  logic [1:0]        cfg_width,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_freerun,
    input  logic              stall_in,
    output logic              port_clk,
    output logic              port_sync,
    output logic [PORT_W-1:0] port_data
);
    logic     phase;
    logic     rise_tick;
    logic     active;
    logic     last;
    logic     load;
    logic     sync_q;
    trc_evt_t evt;
    pw_e      width;

    assign width    = pw_e'(cfg_width);
    assign evt      = '{stat: evt_stat, dest: evt_dest, size: evt_size,
                        addr: evt_addr, data: evt_data};

    trc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (cfg_div),
        .phase     (phase),
        .rise_tick (rise_tick)
    );

    // Start a packet only on a tick at a packet boundary, with data and no stall.
    assign load    = rise_tick & last & evt_valid & ~stall_in;
    assign evt_pop = load;

    trc_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (rise_tick),
        .load   (load),
        .word   (evt),
        .width  (width),
        .beat   (port_data),
        .active (active),
        .last   (last)
    );

    // Start strobe lasts one port-clock period, from the first beat's edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (rise_tick) begin
            sync_q <= load;
        end
    end

    // Port clock is gated off between packets unless free-running is selected.
    assign port_clk  = phase & (cfg_freerun | active);
    assign port_sync = sync_q;

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pop |-> evt_valid); // R10
    AST_STALL_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |-> !evt_pop); // R9
    AST_SYNC_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (port_sync != $past(port_sync)) |-> $past(rise_tick)); // R6
    AST_SYNC_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        port_sync |-> active); // R6
endmodule

// File: tb/trace_pkt_port_test.sv
// Bench for the trace packet port. It holds a model queue and a port-side receiver
// that rebuilds packets from the beats and compares each one with a word computed
// here from the event fields.
module trace_pkt_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid;
    logic        evt_pop;
    logic [1:0]  evt_stat, evt_dest, evt_size;
    logic [17:0] evt_addr;
    logic [7:0]  evt_data;
    logic [1:0]  cfg_width = 2'b00;
    logic [7:0]  cfg_div = 8'd0;
    logic        cfg_freerun = 1'b0;
    logic        stall_in = 1'b0;
    logic        port_clk, port_sync;
    logic [15:0] port_data;

    logic [1:0]  q_stat [0:255];
    logic [1:0]  q_dest [0:255];
    logic [1:0]  q_size [0:255];
    logic [17:0] q_addr [0:255];
    logic [7:0]  q_data [0:255];
    logic [7:0]  wr_ptr = 8'd0;
    logic [7:0]  rd_ptr;

    int total = 0, bad = 0;
    int cyc = 0, last_rise = 0, stall_age = 0, rx_idx = 0, beat_i = 0;
    bit last_ok = 0, collecting = 0, mon_on = 0, prev_clk = 0;
    logic [31:0] acc;

    always #4 clk = ~clk;

    trace_pkt_port uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_pop(evt_pop),
        .evt_stat(evt_stat), .evt_dest(evt_dest), .evt_size(evt_size),
        .evt_addr(evt_addr), .evt_data(evt_data), .cfg_width(cfg_width),
        .cfg_div(cfg_div), .cfg_freerun(cfg_freerun), .stall_in(stall_in),
        .port_clk(port_clk), .port_sync(port_sync), .port_data(port_data)
    );

    assign evt_valid = (rd_ptr != wr_ptr);
    assign evt_stat  = q_stat[rd_ptr];
    assign evt_dest  = q_dest[rd_ptr];
    assign evt_size  = q_size[rd_ptr];
    assign evt_addr  = q_addr[rd_ptr];
    assign evt_data  = q_data[rd_ptr];

    always @(posedge clk) begin
        if (!rst_n) rd_ptr <= 8'd0;
        else if (evt_pop) rd_ptr <= rd_ptr + 8'd1;
    end

    // R4: the expected packet word, status in the top bits.
    function automatic logic [31:0] exp_word(input int i);
        return {q_stat[i], q_dest[i], q_size[i], q_addr[i], q_data[i]};
    endfunction

    function automatic int pins(input logic [1:0] w);
        return 2 << w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] s, input logic [1:0] d, input logic [1:0] z,
                        input logic [17:0] a, input logic [7:0] v);
        @(posedge clk); #1;
        q_stat[wr_ptr] = s; q_dest[wr_ptr] = d; q_size[wr_ptr] = z;
        q_addr[wr_ptr] = a; q_data[wr_ptr] = v;
        wr_ptr = wr_ptr + 8'd1;
    endtask

    task automatic push_rand();
        push(2'($urandom), 2'($urandom), 2'($urandom), 18'($urandom), 8'($urandom));
    endtask

    task automatic do_reset(input logic [1:0] w, input logic [7:0] n, input bit fr);
        @(posedge clk); #1;
        rst_n = 1'b0; mon_on = 0; stall_in = 1'b0;
        cfg_width = w; cfg_div = n; cfg_freerun = fr;
        wr_ptr = 8'd0; rx_idx = 0; collecting = 0; last_ok = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(port_clk == 1'b0 && port_sync == 1'b0 && port_data == 16'h0, "R1 reset",
            {15'h0, port_clk, port_sync, port_data}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1; mon_on = 1;
        @(negedge clk);
        chk(port_clk == 1'b0 && port_sync == 1'b0 && port_data == 16'h0, "R1 after reset",
            {15'h0, port_clk, port_sync, port_data}, 32'h0);
    endtask

    task automatic drain(input int n);
        int guard = 0;
        stall_in = 1'b0;
        while (rx_idx != n && guard < 30000) begin
            @(posedge clk); guard++;
        end
        chk(rx_idx == n && rd_ptr == wr_ptr, "R10 all events sent once",
            32'(rx_idx), 32'(n));
        if (!cfg_freerun) begin
            repeat (4 * (int'(cfg_div) + 1) + 2) @(posedge clk);
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                chk(!port_clk && !port_sync && port_data == 16'h0, "R3 gated idle",
                    {15'h0, port_clk, port_sync, port_data}, 32'h0);
            end
        end
    endtask

    task automatic run_cfg(input logic [1:0] w, input logic [7:0] n, input bit fr,
                           input int cnt);
        int guard = 0;
        do_reset(w, n, fr);
        for (int k = 0; k < cnt / 2; k++) push_rand();
        repeat ($urandom % 60) @(posedge clk);
        for (int k = cnt / 2; k < cnt; k++) push_rand();
        while (rx_idx != cnt && guard < 200) begin
            @(posedge clk); #1;
            stall_in = (($urandom % 3) == 0);
            repeat ($urandom % 40 + 1) @(posedge clk);
            guard++;
        end
        #1;
        drain(cnt);
    endtask

    // Port-side receiver and timing checks, sampled on falling system edges.
    task automatic monitor();
        forever begin
            @(negedge clk);
            cyc++;
            stall_age = stall_in ? stall_age + 1 : 0;
            if (mon_on && port_clk && !prev_clk) begin
                int w;
                w = pins(cfg_width);
                if ((cfg_freerun || collecting) && last_ok)
                    chk(cyc - last_rise == 2 * (int'(cfg_div) + 1), "R2/R7 edge interval",
                        32'(cyc - last_rise), 32'(2 * (int'(cfg_div) + 1)));
                last_rise = cyc; last_ok = 1;
                if (port_sync) begin
                    chk(!collecting, "R8 packet cut short", 32'(beat_i), 32'(32 / w));
                    chk(stall_age < 2, "R9 start under stall", 32'(stall_age), 32'd0);
                    collecting = 1; beat_i = 0; acc = 32'h0;
                end
                if (collecting) begin
                    chk((32'(port_data) >> w) == 32'h0, "R5 unused pins low",
                        32'(port_data), 32'(port_data) & ((32'h1 << w) - 1));
                    acc = (acc << w) | (32'(port_data) & ((32'h1 << w) - 1));
                    beat_i++;
                    if (beat_i == 32 / w) begin
                        chk(acc == exp_word(rx_idx), "R4 packet word", acc,
                            exp_word(rx_idx));
                        rx_idx++; collecting = 0;
                    end
                end else begin
                    chk(!port_sync && port_data == 16'h0, "R6 idle edge quiet",
                        {15'h0, port_sync, port_data}, 32'h0);
                end
            end
            prev_clk = port_clk;
        end
    endtask

    task automatic run_all();
        void'($urandom(32'h5EED_0417));
        // R4 R5: directed byte write on a 4-pin port, gated clock, divide by 4.
        do_reset(2'b01, 8'd1, 1'b0);
        push(2'b00, 2'b01, 2'b00, 18'h12345, 8'hA5);
        drain(1);
        // R7: back-to-back packets on 16 pins, free-running, fastest clock.
        do_reset(2'b11, 8'd0, 1'b1);
        for (int k = 0; k < 4; k++) push_rand();
        drain(4);
        // R8 R9: random configurations with random stall windows, every width.
        for (int i = 0; i < 8; i++)
            run_cfg(2'(i), 8'($urandom % 4), bit'(i / 4), 20);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
            end
            monitor();
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule